// File: doc/BRIEF.md
# SRAM Bus Interface Controller

This block turns requests from an internal port into the strobe, address and data activity of an external asynchronous static RAM. Each request carries an address, a read/write flag, an access size, write data placed in its byte lanes, and a flag that asks for a whole 32-byte line. The controller then runs one or more fixed two-cycle accesses on the external pins. A static configuration input selects an external data bus 16 or 32 bits wide.

A single access takes a first cycle that starts the access and a second cycle that completes it. The start strobe is active only in the first cycle. Chip select covers both cycles. When requests follow each other with no idle cycle, chip select stays active across them. A line request moves 32 bytes as a run of accesses. The run starts at the requested word, steps by the bus width, and wraps inside the aligned 32-byte block. The bus stays held until the last access. Reads always return the full device width, one response per access.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Every external access takes exactly two cycles. The first cycle starts on the clock edge that accepts the request (or that ends the previous access), and the second cycle follows it directly.
- R2: `mem_bs_n` is low for exactly one cycle per access. That cycle is the first cycle of the access.
- R3: `mem_cs_n` is low during both cycles of an access. It is high in the cycle after the second cycle when no further access follows.
- R4: When a new request is accepted on the edge that ends an access, `mem_cs_n` stays low with no high cycle in between. The next start strobe follows right after the previous second cycle.
- R5: A read ignores `req_size`. On a 32-bit bus, `rsp_rdata` returns all 32 pins. On a 16-bit bus, it returns pins 15..0, zero-extended. `rsp_valid` pulses for one cycle, in the cycle after each read access ends.
- R6: On a 32-bit bus, a write drives low only the enables of the lanes being written. Size encoding is 0 = byte, 1 = halfword, 2 = word. Lane i is data bits 8i+7..8i and enable `mem_we_n[i]`. A byte uses lane addr[1:0], a halfword uses lanes {1,0} or {3,2} by addr[1], and a word uses all four. `req_wdata` holds the data in the lanes of its word.
- R7: On a 16-bit bus, `mem_we_n[3:2]` stay high. A byte uses enable addr[0]. A halfword uses enables 1..0. Pins 15..0 carry the request half chosen by addr[1]. A word write becomes two accesses, at addr and at addr+2.
- R8: A line request makes 8 accesses on a 32-bit bus and 16 on a 16-bit bus.
- R9: The first line access uses the requested address, aligned to the bus width. Each later access adds the bus width in bytes, modulo 32, inside the aligned 32-byte block.
- R10: Throughout a line transfer, `mem_cs_n` stays low and `req_ready` stays low until the second cycle of the last access.
- R11: After reset, the outputs are idle: `mem_cs_n`, `mem_bs_n` and `mem_rd_n` are 1, `mem_we_n` is 4'hF, `rsp_valid` is 0 and `req_ready` is 1. `req_ready` is high only when idle or in the second cycle of an access's final beat.
- R12: A line request with `req_write` set runs as a read. `mem_rd_n` is low, `mem_we_n` stays 4'hF, and one response is returned per access.
- R13: `mem_addr` carries the access address with its low bits cleared to the bus width (two bits on 32-bit, one bit on 16-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bus32 | input | 1 | 1 = 32-bit external bus, 0 = 16-bit; static while busy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 26 | Byte address |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data in word lanes |
| req_line | input | 1 | 32-byte line transfer |
| rsp_valid | output | 1 | Read data valid, one cycle per access |
| rsp_rdata | output | 32 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_bs_n | output | 1 | Access start strobe, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 4 | Per-lane write enables, active low |
| mem_addr | output | 26 | External address |
| mem_dq_out | output | 32 | Write data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 32 | Read data pins |

## Verification
The bench uses the default parameters: a 26-bit address and a 32-byte line. It switches `cfg_bus32` between phases, so both 8-beat and 16-beat lines, the split word write and zero-extended half-width reads are all exercised. A byte-wide memory model behind the pins is shared by both widths. Data written through one width is therefore read back through the other against a shadow copy. The line starting addresses are chosen so the wrap back to the block base is seen on both widths.

// File: rtl/sram_bus_pkg.sv
// Shared types for the SRAM bus controller.
package sram_bus_pkg;
    // Access phase: idle, first (start) cycle, second (completion) cycle.
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_T1 = 2'd1, PH_T2 = 2'd2} phase_e;
    // Access size encoding on the request port.
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/sram_bus_seq.sv
// Beat sequencer: runs the two-phase access cycle and steps the beat address.
// Assumes the bus width input is stable while a request is in flight and that
// start is only raised when the sequencer reports it can accept.
module sram_bus_seq
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus32,
    input  logic              start,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              st_write,
    input  logic [1:0]        st_size,
    input  logic              st_line,
    output phase_e            phase,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              last
);
    localparam int CNT_W        = $clog2(LINE_BYTES);
    localparam int BEATS_W32    = LINE_BYTES / 4;
    localparam int BEATS_W16    = LINE_BYTES / 2;

    logic [CNT_W-1:0]  left;
    logic [ADDR_W-1:0] wmask;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] load_addr;
    logic [CNT_W-1:0]  load_left;

    // Address step, wrapped increment, and the values loaded at acceptance.
    always_comb begin
        step      = bus32 ? ADDR_W'(4) : ADDR_W'(2);
        nxt_addr  = (beat_addr & ~wmask) | ((beat_addr + step) & wmask);
        load_addr = st_addr & ~(bus32 ? ADDR_W'(3) : ADDR_W'(1));
        if (st_line)
            load_left = bus32 ? CNT_W'(BEATS_W32 - 1) : CNT_W'(BEATS_W16 - 1);
        else if (!bus32 && st_write && st_size == SZ_WORD)
            load_left = CNT_W'(1);
        else
            load_left = '0;
    end

    assign last = (left == '0);

    // Phase, beat counter and beat address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            left      <= '0;
            beat_addr <= '0;
            wmask     <= '0;
        end else if (start) begin
            phase     <= PH_T1;
            left      <= load_left;
            beat_addr <= load_addr;
            wmask     <= st_line ? ADDR_W'(LINE_BYTES - 1) : ADDR_W'(3);
        end else begin
            case (phase)
                PH_T1: phase <= PH_T2;
                PH_T2: begin
                    if (!last) begin
                        phase     <= PH_T1;
                        left      <= left - CNT_W'(1);
                        beat_addr <= nxt_addr;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R1
    t1_then_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2));
    // R9
    step_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 && !last && !start) |=>
        ((beat_addr & ~wmask) == ($past(beat_addr) & ~$past(wmask))));
endmodule

// File: rtl/sram_bus_lane.sv
// Lane decode: picks write enables and places write data on the pins for
// the configured width. Assumes naturally aligned requests and request data
// already sitting in the byte lanes of its 32-bit word.
module sram_bus_lane
    import sram_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              bus32,
    input  logic              active,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [1:0]        lo,
    input  logic              half_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int HALF = DATA_W / 2;

    logic [LANES-1:0] en;

    // Lane enable pattern for the access size and width.
    always_comb begin
        en = '0;
        if (bus32) begin
            case (size)
                SZ_BYTE: en[lo] = 1'b1;
                SZ_HALF: en = lo[1] ? LANES'(4'b1100) : LANES'(4'b0011);
                default: en = '1;
            endcase
        end else begin
            if (size == SZ_BYTE) en[{1'b0, lo[0]}] = 1'b1;
            else                 en = LANES'(4'b0011);
        end
    end

    // Active-low enables and pin data for the current beat.
    always_comb begin
        we_n   = (active && write) ? ~en : '1;
        dq_oe  = active && write;
        dq_out = wdata;
        if (!bus32)
            dq_out[HALF-1:0] = half_sel ? wdata[DATA_W-1:HALF] : wdata[HALF-1:0];
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
// SRAM bus controller top: accepts requests, runs fixed two-cycle accesses
// through the sequencer, decodes lanes and captures read data.
// Assumes cfg_bus32 changes only while the controller is idle.
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int LANES      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus32,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_line,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_bs_n,
    output logic              mem_rd_n,
    output logic [LANES-1:0]  mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int HALF = DATA_W / 2;

    phase_e            phase;
    logic [ADDR_W-1:0] beat_addr;
    logic              last;
    logic              start;
    logic              eff_write;
    logic              op_write;
    logic [1:0]        op_size;
    logic [1:0]        op_lo;
    logic [DATA_W-1:0] op_wdata;
    logic              active;

    assign req_ready = (phase == PH_IDLE) || (phase == PH_T2 && last);
    assign start     = req_valid && req_ready;
    assign eff_write = req_write && !req_line;
    assign active    = (phase != PH_IDLE);

    sram_bus_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus32(cfg_bus32), .start(start),
        .st_addr(req_addr), .st_write(eff_write), .st_size(req_size),
        .st_line(req_line), .phase(phase), .beat_addr(beat_addr), .last(last)
    );

    // Request attributes held for the whole run of beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_size  <= SZ_BYTE;
            op_lo    <= '0;
            op_wdata <= '0;
        end else if (start) begin
            op_write <= eff_write;
            op_size  <= req_size;
            op_lo    <= req_addr[1:0];
            op_wdata <= req_wdata;
        end
    end

    sram_bus_lane #(.DATA_W(DATA_W), .LANES(LANES)) u_lane (
        .bus32(cfg_bus32), .active(active), .write(op_write), .size(op_size),
        .lo(op_lo), .half_sel(beat_addr[1]), .wdata(op_wdata),
        .we_n(mem_we_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
    );

    assign mem_cs_n = !active;
    assign mem_bs_n = (phase != PH_T1);
    assign mem_rd_n = !(active && !op_write);
    assign mem_addr = beat_addr;

    // Capture full-width read data at the end of each read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (phase == PH_T2) && !op_write;
            if (phase == PH_T2 && !op_write)
                rsp_rdata <= cfg_bus32 ? mem_dq_in : {{HALF{1'b0}}, mem_dq_in[HALF-1:0]};
        end
    end

    // R2
    bs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_bs_n |=> mem_bs_n);
    // R3
    cs_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_bs_n |-> (!mem_cs_n ##1 !mem_cs_n));
    // R6
    we_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1) |-> (!mem_cs_n && mem_rd_n));
    // R7
    upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bus32 |-> (mem_we_n[LANES-1:2] == '1));
    // R5
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_cs_n && mem_bs_n && !mem_rd_n));
    // R10
    no_accept_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_bs_n) |-> !req_ready);
endmodule

// File: tb/sram_bus_ctrl_bench.sv
// Scoreboard bench: driver pushes expected read words, monitor compares.
module sram_bus_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus32 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        req_line = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_cs_n, mem_bs_n, mem_rd_n, mem_dq_oe;
    logic [3:0]  mem_we_n;
    logic [25:0] mem_addr;
    logic [31:0] mem_dq_out;
    logic [31:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  mem_b [256];
    logic [7:0]  sh    [256];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl u_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_bus32(cfg_bus32),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_line(req_line), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_bs_n(mem_bs_n), .mem_rd_n(mem_rd_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model read path; upper half is junk on a 16-bit bus.
    always_comb begin
        int b;
        b = int'(mem_addr[7:0]);
        if (cfg_bus32) begin
            b = b & ~3;
            mem_dq_in = {mem_b[(b+3)&255], mem_b[(b+2)&255], mem_b[(b+1)&255], mem_b[b]};
        end else begin
            b = b & ~1;
            mem_dq_in = {16'hA5A5, mem_b[(b+1)&255], mem_b[b]};
        end
    end

    // Memory model write path driven by the lane enables.
    always @(posedge clk) begin
        if (rst_n && !mem_cs_n && mem_dq_oe) begin
            for (int i = 0; i < 4; i++) begin
                if (!mem_we_n[i]) begin
                    int b;
                    b = int'(mem_addr[7:0]) & (cfg_bus32 ? ~3 : ~1);
                    mem_b[(b+i)&255] <= mem_dq_out[8*i +: 8];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_exp(input int a, input bit b32);
        int b;
        if (b32) begin
            b = a & ~3;
            return {sh[(b+3)&255], sh[(b+2)&255], sh[(b+1)&255], sh[b&255]};
        end
        b = a & ~1;
        return {16'h0, sh[(b+1)&255], sh[b&255]};
    endfunction

    // Monitor: compare each response against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    // Driver: present a request, wait for acceptance, return in the first cycle.
    task automatic issue(input int a, input bit wr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit ln, input string tag);
        bit b32;
        b32 = cfg_bus32;
        req_addr = 26'(a); req_write = wr; req_size = sz; req_wdata = wd; req_line = ln;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        if (ln) begin
            int stp, n, al;
            stp = b32 ? 4 : 2;
            n = 32 / stp;
            al = a & ~(stp - 1);
            for (int k = 0; k < n; k++) begin
                exp_q.push_back(rd_exp((a & ~31) | ((al + k*stp) & 31), b32));
                tag_q.push_back(tag);
            end
        end else if (!wr) begin
            exp_q.push_back(rd_exp(a, b32));
            tag_q.push_back(tag);
        end else begin
            int nb;
            nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            for (int i = 0; i < nb; i++)
                sh[(a+i)&255] = wd[8*(((a+i)&3)) +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Line beat checker, entered in the first cycle of beat 0.
    task automatic line_check(input int a, input bit b32, input string tag);
        int stp, n, al;
        stp = b32 ? 4 : 2;
        n = 32 / stp;
        al = a & ~(stp - 1);
        for (int k = 0; k < n; k++) begin
            int ea;
            ea = (a & ~31) | ((al + k*stp) & 31);
            chk(mem_addr == 26'(ea), {tag, " R9 beat address"}, 32'(mem_addr), 32'(ea));
            chk(!mem_bs_n && !mem_cs_n && !req_ready, {tag, " R10 start cycle"},
                {29'b0, mem_bs_n, mem_cs_n, req_ready}, 32'h0);
            chk(!mem_rd_n && mem_we_n == 4'hF, {tag, " R12 read strobes"},
                {27'b0, mem_rd_n, mem_we_n}, 32'hF);
            @(negedge clk);
            chk(mem_bs_n && !mem_cs_n, {tag, " R10 second cycle"},
                {30'b0, mem_bs_n, mem_cs_n}, 32'h2);
            chk(req_ready == (k == n-1), {tag, " R10 ready only on last"},
                {31'b0, req_ready}, {31'b0, k == n-1});
            @(negedge clk);
        end
        chk(mem_cs_n, {tag, " R8 released after last beat"}, {31'b0, mem_cs_n}, 32'h1);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_b[i] = 8'(i * 7 + 3);
            sh[i]    = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(mem_cs_n && mem_bs_n && mem_rd_n && mem_we_n == 4'hF && !rsp_valid && req_ready,
            "R11 reset idle", {26'b0, mem_cs_n, mem_bs_n, mem_rd_n, rsp_valid, req_ready, 1'b0},
            32'h3A);
        rst_n = 1'b1;
        @(negedge clk);

        // 32-bit single read: timing R1 R2 R3, size ignored R5, aligned address R13
        cfg_bus32 = 1'b1;
        issue(32'h12, 1'b0, 2'd0, 32'h0, 1'b0, "R5 byte-size read returns word");
        chk(!mem_bs_n && !mem_cs_n && !mem_rd_n, "R2 first cycle strobes",
            {29'b0, mem_bs_n, mem_cs_n, mem_rd_n}, 32'h0);
        chk(mem_addr == 26'h10, "R13 address aligned to 32-bit", 32'(mem_addr), 32'h10);
        @(negedge clk);
        chk(mem_bs_n && !mem_cs_n, "R1 second cycle", {30'b0, mem_bs_n, mem_cs_n}, 32'h2);
        @(negedge clk);
        chk(mem_cs_n && mem_bs_n, "R3 released after second cycle",
            {30'b0, mem_bs_n, mem_cs_n}, 32'h3);
        drain();

        // 32-bit writes: lane enables R6
        issue(32'h21, 1'b1, 2'd0, 32'h0000AB00, 1'b0, "R6");
        chk(mem_we_n == 4'b1101 && mem_dq_oe && mem_rd_n, "R6 byte lane 1",
            {27'b0, mem_rd_n, mem_we_n}, 32'h1D);
        drain();
        issue(32'h26, 1'b1, 2'd1, 32'hCDEF0000, 1'b0, "R6");
        chk(mem_we_n == 4'b0011, "R6 upper half lanes", {28'b0, mem_we_n}, 32'h3);
        drain();
        issue(32'h28, 1'b1, 2'd2, 32'h44332211, 1'b0, "R6");
        chk(mem_we_n == 4'b0000 && mem_dq_out == 32'h44332211, "R6 word lanes and data",
            mem_dq_out, 32'h44332211);
        drain();

        // Back-to-back reads R4 with readback of the writes R6
        issue(32'h20, 1'b0, 2'd2, 32'h0, 1'b0, "R6 readback 0x20");
        issue(32'h24, 1'b0, 2'd2, 32'h0, 1'b0, "R6 readback 0x24");
        chk(!mem_bs_n && !mem_cs_n, "R4 second start follows directly",
            {30'b0, mem_bs_n, mem_cs_n}, 32'h0);
        issue(32'h28, 1'b0, 2'd2, 32'h0, 1'b0, "R6 readback 0x28");
        chk(!mem_bs_n && !mem_cs_n && mem_addr == 26'h28, "R4 third start no gap",
            32'(mem_addr), 32'h28);
        drain();

        // 32-bit line read with wrap R8 R9 R10
        issue(32'h14, 1'b0, 2'd2, 32'h0, 1'b1, "R8 line32 data");
        line_check(32'h14, 1'b1, "line32");
        drain();

        // Line request with write flag runs as read R12
        issue(32'h0C, 1'b1, 2'd2, 32'hFFFFFFFF, 1'b1, "R12 line write flag reads");
        line_check(32'h0C, 1'b1, "R12 line32w");
        drain();

        // 16-bit bus: read zero-extension R5, address R13
        cfg_bus32 = 1'b0;
        @(negedge clk);
        issue(32'h23, 1'b0, 2'd2, 32'h0, 1'b0, "R5 16-bit read zero-extended");
        chk(mem_addr == 26'h22, "R13 address aligned to 16-bit", 32'(mem_addr), 32'h22);
        drain();

        // 16-bit byte write on lane 3 R7
        issue(32'h33, 1'b1, 2'd0, 32'h9C000000, 1'b0, "R7");
        chk(mem_we_n == 4'b1101 && mem_dq_out[15:8] == 8'h9C, "R7 byte on high lane",
            {20'b0, mem_dq_out[15:8], mem_we_n}, {20'b0, 8'h9C, 4'b1101});
        drain();

        // 16-bit word write split into two accesses R7
        issue(32'h38, 1'b1, 2'd2, 32'hBEEF1234, 1'b0, "R7");
        chk(mem_addr == 26'h38 && mem_we_n == 4'b1100 && mem_dq_out[15:0] == 16'h1234,
            "R7 split first half", {mem_dq_out[15:0], 16'(mem_addr)}, {16'h1234, 16'h38});
        @(negedge clk);
        @(negedge clk);
        chk(!mem_bs_n && mem_addr == 26'h3A && mem_dq_out[15:0] == 16'hBEEF,
            "R7 split second half", {mem_dq_out[15:0], 16'(mem_addr)}, {16'hBEEF, 16'h3A});
        drain();

        // Readbacks across widths
        issue(32'h38, 1'b0, 2'd1, 32'h0, 1'b0, "R7 readback 0x38");
        issue(32'h3A, 1'b0, 2'd1, 32'h0, 1'b0, "R7 readback 0x3A");
        issue(32'h32, 1'b0, 2'd0, 32'h0, 1'b0, "R7 readback 0x32");
        drain();
        cfg_bus32 = 1'b1;
        @(negedge clk);
        issue(32'h38, 1'b0, 2'd2, 32'h0, 1'b0, "R7 32-bit view of split write");
        drain();

        // 16-bit line read with wrap R8 R9 R10
        cfg_bus32 = 1'b0;
        @(negedge clk);
        issue(32'h4A, 1'b0, 2'd1, 32'h0, 1'b1, "R8 line16 data");
        line_check(32'h4A, 1'b0, "line16");
        drain();

        chk(exp_q.size() == 0, "R5 all responses returned", 32'(exp_q.size()), 32'h0);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule